// File: doc/BRIEF.md
# Register Region Access Checker

This block sits between a register bus and a register bank. Every access arrives as a byte offset, a size in bytes, a direction and (for writes) a data word. The block compares the offset against a table of register regions. Each entry holds a base, a length, the access widths it allows and the density of interrupt state it stores. From that comparison it decides in one cycle whether the access may reach the bank.

An accepted access is passed downstream with the index of its region and its offset relative to that region's base. The register logic can use that offset directly. An access can be rejected for several reasons: no region matches, the size is illegal or not allowed there, the address is misaligned, or the access points at an interrupt that has not been allocated. A rejected access fails silently: a rejected read returns zero and a rejected write never asserts the write enable. Data is little-endian and right-justified. An access of N bytes uses byte lanes 0 to N-1, and the other lanes are forced to zero in both directions.

Top module: `region_access_checker`

## Requirements
- R1: An offset falls in a region when it is at or above the region base and below base plus length. An offset that falls in no region is rejected.
- R2: The only legal access sizes are 1, 4 and 8 bytes. Any other value of `req_size` is rejected.
- R3: Each region carries a size permission mask: bit 0 allows 1-byte, bit 1 allows 4-byte and bit 2 allows 8-byte accesses. A size whose bit is clear is rejected.
- R4: The absolute offset must be a multiple of the access size. A misaligned access is rejected.
- R5: A region with a nonzero bits-per-interrupt count B addresses interrupt number (relative offset × 8 / B). The access is rejected unless that number is below 32 + `spi_count`.
- R6: A region whose bits-per-interrupt count is zero skips the interrupt limit of R5, whatever `spi_count` is.
- R7: A rejected read drives `rsp_rdata` to zero. A rejected write leaves `dec_wr_en` low and `dec_wdata` zero. No error indication exists.
- R8: Data is little-endian. On an accepted access of N bytes, byte lane k (bits 8k+7..8k) passes only for k < N. Higher lanes of `dec_wdata` and `rsp_rdata` read zero.
- R9: On an accepted access, `dec_region` gives the matched table index and `dec_rel_offset` gives the offset minus that region's base.
- R10: The decision appears on the `dec_*` outputs one clock after `req_valid` is sampled. `dec_valid` is low after reset and in any cycle after `req_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 16 | Byte offset within the register window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, little-endian, right-justified |
| spi_count | input | 10 | Number of allocated shared interrupts |
| reg_rdata | input | 64 | Read data returned by the register bank |
| dec_valid | output | 1 | Registered request present |
| dec_write | output | 1 | Registered direction |
| dec_accept | output | 1 | Access passed every check |
| dec_region | output | 3 | Matched region index |
| dec_rel_offset | output | 16 | Offset relative to the matched region base |
| dec_size | output | 4 | Registered access size in bytes |
| dec_wr_en | output | 1 | Write enable toward the register bank |
| dec_wdata | output | 64 | Lane-masked write data |
| rsp_rdata | output | 64 | Lane-masked read data, zero when rejected |

## Verification
A faulty region comparator or rule would show up on `dec_accept` or `dec_region` on the very next clock after the request. The bench therefore checks every access against a table-driven reference one cycle after issue. The stimulus aims at the first and last byte of each region, one byte past the end, and interrupt numbers just under and just at the allocated limit. Lane masking and the zeroing of rejected responses are visible on the data ports in the same cycle, so an error in either shows up on the access that caused it.

// File: rtl/rac_pkg.sv
package rac_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 64;
    localparam int LANES     = DATA_W / 8;
    localparam int SPI_W     = 10;
    localparam int SIZE_W    = 4;
    localparam int PRIV_IRQS = 32;
    localparam int INTID_W   = ADDR_W + 3;
    localparam int DEF_NUM_REGIONS = 6;

    // One register region. irq_shift is log2 of bits-per-interrupt,
    // only meaningful when per_irq is set.
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   len;
        logic [2:0]        size_ok;   // [0]=1B [1]=4B [2]=8B
        logic              per_irq;
        logic [2:0]        irq_shift;
    } region_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } size_class_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              accept;
        logic [ADDR_W-1:0] rel;
        logic [SIZE_W-1:0] size;
    } dec_t;

    function automatic size_class_e classify_size(input logic [SIZE_W-1:0] nbytes);
        case (nbytes)
            4'd1:    return SZ_BYTE;
            4'd4:    return SZ_WORD;
            4'd8:    return SZ_DWORD;
            default: return SZ_BAD;
        endcase
    endfunction

    function automatic region_t mk_region(input int base, input int len,
                                          input logic [2:0] ok, input int bpi);
        region_t r;
        r.base    = ADDR_W'(base);
        r.len     = (ADDR_W+1)'(len);
        r.size_ok = ok;
        r.per_irq = (bpi != 0);
        r.irq_shift = 3'd0;
        for (int s = 0; s < 8; s++)
            if (bpi == (1 << s)) r.irq_shift = 3'(s);
        return r;
    endfunction

    localparam region_t [DEF_NUM_REGIONS-1:0] DEFAULT_REGIONS = '{
        5: mk_region('h6000, 'h2000, 3'b110, 64),
        4: mk_region('h0C00, 'h0100, 3'b010, 2),
        3: mk_region('h0400, 'h0400, 3'b011, 8),
        2: mk_region('h0100, 'h0080, 3'b010, 1),
        1: mk_region('h0080, 'h0080, 3'b010, 1),
        0: mk_region('h0000, 'h0010, 3'b010, 0)
    };

endpackage

// File: rtl/rac_region_match.sv
module rac_region_match
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS = DEF_NUM_REGIONS,
    parameter region_t [NUM_REGIONS-1:0] REGIONS = DEFAULT_REGIONS,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic [ADDR_W-1:0] offset,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] rel
);
    logic [NUM_REGIONS-1:0] hits;

    // One comparator pair per region, all in parallel.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [ADDR_W:0] lo, hi_excl, off_w;
        assign lo      = {1'b0, REGIONS[g].base};
        assign hi_excl = lo + REGIONS[g].len;
        assign off_w   = {1'b0, offset};
        assign hits[g] = (off_w >= lo) && (off_w < hi_excl);
    end

    always_comb begin
        idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--)
            if (hits[i]) idx = IDX_W'(i);
    end

    assign hit = |hits;
    assign rel = hit ? (offset - REGIONS[idx].base) : '0;

endmodule

// File: rtl/rac_rule_check.sv
module rac_rule_check
    import rac_pkg::*;
(
    input  logic              hit,
    input  region_t           region,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] rel,
    input  logic [SIZE_W-1:0] size,
    input  logic [SPI_W-1:0]  spi_count,
    output logic              accept
);
    size_class_e      cls;
    logic             size_legal;
    logic             size_allowed;
    logic             aligned;
    logic             irq_ok;
    logic [INTID_W-1:0] intid;
    logic [INTID_W-1:0] irq_limit;

    assign cls        = classify_size(size);
    assign size_legal = (cls != SZ_BAD);

    always_comb begin
        size_allowed = 1'b0;
        aligned      = 1'b0;
        case (cls)
            SZ_BYTE: begin
                size_allowed = region.size_ok[0];
                aligned      = 1'b1;
            end
            SZ_WORD: begin
                size_allowed = region.size_ok[1];
                aligned      = (offset[1:0] == 2'b00);
            end
            SZ_DWORD: begin
                size_allowed = region.size_ok[2];
                aligned      = (offset[2:0] == 3'b000);
            end
            default: begin
                size_allowed = 1'b0;
                aligned      = 1'b0;
            end
        endcase
    end

    // Interrupt number = relative byte offset * 8 / bits-per-interrupt.
    assign intid     = {rel, 3'b000} >> region.irq_shift;
    assign irq_limit = INTID_W'(PRIV_IRQS) + INTID_W'(spi_count);
    assign irq_ok    = !region.per_irq || (intid < irq_limit);

    assign accept = hit && size_legal && size_allowed && aligned && irq_ok;

endmodule

// File: rtl/rac_lane_mask.sv
module rac_lane_mask
    import rac_pkg::*;
(
    input  logic              pass,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Little-endian: lane k carries bits 8k+7..8k and is live for k < size.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic live;
        assign live = pass && (SIZE_W'(k) < size);
        assign dout[8*k +: 8] = live ? din[8*k +: 8] : 8'h00;
    end

endmodule

// File: rtl/region_access_checker.sv
module region_access_checker
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS = DEF_NUM_REGIONS,
    parameter region_t [NUM_REGIONS-1:0] REGIONS = DEFAULT_REGIONS,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SPI_W-1:0]  spi_count,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              dec_valid,
    output logic              dec_write,
    output logic              dec_accept,
    output logic [IDX_W-1:0]  dec_region,
    output logic [ADDR_W-1:0] dec_rel_offset,
    output logic [SIZE_W-1:0] dec_size,
    output logic              dec_wr_en,
    output logic [DATA_W-1:0] dec_wdata,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic              m_hit;
    logic [IDX_W-1:0]  m_idx;
    logic [ADDR_W-1:0] m_rel;
    logic              c_accept;
    logic [DATA_W-1:0] w_masked;
    dec_t              dec_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q;

    rac_region_match #(
        .NUM_REGIONS(NUM_REGIONS),
        .REGIONS    (REGIONS)
    ) u_match (
        .offset(req_offset),
        .hit   (m_hit),
        .idx   (m_idx),
        .rel   (m_rel)
    );

    rac_rule_check u_rules (
        .hit      (m_hit),
        .region   (REGIONS[m_idx]),
        .offset   (req_offset),
        .rel      (m_rel),
        .size     (req_size),
        .spi_count(spi_count),
        .accept   (c_accept)
    );

    rac_lane_mask u_wlane (
        .pass(req_valid && req_write && c_accept),
        .size(req_size),
        .din (req_wdata),
        .dout(w_masked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q   <= '0;
            idx_q   <= '0;
            wdata_q <= '0;
        end else begin
            dec_q.valid  <= req_valid;
            dec_q.write  <= req_write;
            dec_q.accept <= req_valid && c_accept;
            dec_q.rel    <= m_rel;
            dec_q.size   <= req_size;
            idx_q        <= m_idx;
            wdata_q      <= w_masked;
        end
    end

    rac_lane_mask u_rlane (
        .pass(dec_q.valid && !dec_q.write && dec_q.accept),
        .size(dec_q.size),
        .din (reg_rdata),
        .dout(rsp_rdata)
    );

    assign dec_valid      = dec_q.valid;
    assign dec_write      = dec_q.write;
    assign dec_accept     = dec_q.accept;
    assign dec_region     = idx_q;
    assign dec_rel_offset = dec_q.rel;
    assign dec_size       = dec_q.size;
    assign dec_wr_en      = dec_q.valid && dec_q.write && dec_q.accept;
    assign dec_wdata      = wdata_q;

endmodule

// File: rtl/rac_checker.sv
module rac_checker
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS = DEF_NUM_REGIONS,
    parameter region_t [NUM_REGIONS-1:0] REGIONS = DEFAULT_REGIONS,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [SIZE_W-1:0] req_size,
    input logic              dec_valid,
    input logic              dec_write,
    input logic              dec_accept,
    input logic [IDX_W-1:0]  dec_region,
    input logic [ADDR_W-1:0] dec_rel_offset,
    input logic [SIZE_W-1:0] dec_size,
    input logic              dec_wr_en,
    input logic [DATA_W-1:0] dec_wdata,
    input logic [DATA_W-1:0] rsp_rdata
);
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> dec_valid);

    a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !dec_valid && !dec_wr_en);

    a_r2_bad_size_rejected: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size != 4'd1 && req_size != 4'd4 && req_size != 4'd8)
        |=> !dec_accept);

    a_r7_reject_read_zero: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |-> (rsp_rdata == '0));

    a_r7_reject_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |-> (!dec_wr_en && dec_wdata == '0));

    a_r8_byte_lanes: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_size == 4'd1) |-> (rsp_rdata[DATA_W-1:8] == '0 &&
                                             dec_wdata[DATA_W-1:8] == '0));

    a_r9_rel_in_region: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> ({1'b0, dec_rel_offset} < REGIONS[dec_region].len));

    a_r4_aligned_rel: assert property (@(posedge clk) disable iff (rst)
        (dec_accept && dec_size == 4'd8) |-> (dec_rel_offset[2:0] == 3'b000));

    a_r7_wr_en_only_writes: assert property (@(posedge clk) disable iff (rst)
        dec_wr_en |-> dec_write);

endmodule

bind region_access_checker rac_checker #(
    .NUM_REGIONS(NUM_REGIONS),
    .REGIONS    (REGIONS)
) u_rac_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_size      (req_size),
    .dec_valid     (dec_valid),
    .dec_write     (dec_write),
    .dec_accept    (dec_accept),
    .dec_region    (dec_region),
    .dec_rel_offset(dec_rel_offset),
    .dec_size      (dec_size),
    .dec_wr_en     (dec_wr_en),
    .dec_wdata     (dec_wdata),
    .rsp_rdata     (rsp_rdata)
);

// File: tb/tb_region_access_checker.sv
module tb_region_access_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_offset;
    logic [3:0]  req_size;
    logic [63:0] req_wdata;
    logic [9:0]  spi_count;
    logic [63:0] reg_rdata;
    logic        dec_valid, dec_write, dec_accept, dec_wr_en;
    logic [2:0]  dec_region;
    logic [15:0] dec_rel_offset;
    logic [3:0]  dec_size;
    logic [63:0] dec_wdata, rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference table, written from the requirements.
    int T_BASE [6] = '{'h0000, 'h0080, 'h0100, 'h0400, 'h0C00, 'h6000};
    int T_LEN  [6] = '{'h0010, 'h0080, 'h0080, 'h0400, 'h0100, 'h2000};
    int T_OK   [6] = '{2, 2, 2, 3, 2, 6};
    int T_BPI  [6] = '{0, 1, 1, 8, 2, 64};

    always #2.5 clk = ~clk;

    region_access_checker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .spi_count(spi_count), .reg_rdata(reg_rdata), .dec_valid(dec_valid),
        .dec_write(dec_write), .dec_accept(dec_accept), .dec_region(dec_region),
        .dec_rel_offset(dec_rel_offset), .dec_size(dec_size),
        .dec_wr_en(dec_wr_en), .dec_wdata(dec_wdata), .rsp_rdata(rsp_rdata)
    );

    function automatic void ref_eval(input int off, input int sz, input int spi,
                                     output bit acc, output int idx, output int rel);
        int bit_ok;
        acc = 0; idx = -1; rel = 0;
        for (int i = 0; i < 6; i++)
            if (off >= T_BASE[i] && off < T_BASE[i] + T_LEN[i]) begin
                idx = i; rel = off - T_BASE[i];
            end
        if (idx < 0) return;
        if (sz == 1) bit_ok = 1; else if (sz == 4) bit_ok = 2;
        else if (sz == 8) bit_ok = 4; else return;
        if ((T_OK[idx] & bit_ok) == 0) return;
        if ((off % sz) != 0) return;
        if (T_BPI[idx] != 0 && (rel * 8 / T_BPI[idx]) >= 32 + spi) return;
        acc = 1;
    endfunction

    function automatic logic [63:0] lane_mask(input int sz);
        logic [63:0] m = '0;
        for (int k = 0; k < 8; k++)
            if (k < sz) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one access, check all outputs one cycle later.
    task automatic access(input int off, input int sz, input bit wr, input int spi,
                          input logic [63:0] wd, input logic [63:0] rd, input string tag);
        bit acc; int idx; int rel;
        logic [63:0] exp_w, exp_r;
        ref_eval(off, sz, spi, acc, idx, rel);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = 16'(off);
        req_size   = 4'(sz);
        req_wdata  = wd;
        spi_count  = 10'(spi);
        reg_rdata  = rd;
        @(negedge clk);
        exp_w = (acc && wr)  ? (wd & lane_mask(sz)) : '0;
        exp_r = (acc && !wr) ? (rd & lane_mask(sz)) : '0;
        check(dec_valid == 1'b1, "R10", {tag, " valid"}, 64'(dec_valid), 64'd1);
        check(dec_accept == acc, tag, "accept", 64'(dec_accept), 64'(acc));
        if (acc) begin
            check(dec_region == 3'(idx) && dec_rel_offset == 16'(rel), "R9",
                  {tag, " region/rel"}, {45'd0, dec_region, dec_rel_offset},
                  {45'd0, 3'(idx), 16'(rel)});
        end
        check(dec_wr_en == (acc && wr), "R7", {tag, " wr_en"},
              64'(dec_wr_en), 64'(acc && wr));
        check(dec_wdata == exp_w, "R8", {tag, " wdata"}, dec_wdata, exp_w);
        check(rsp_rdata == exp_r, "R8", {tag, " rdata"}, rsp_rdata, exp_r);
    endtask

    initial begin
        #1_000_000ns;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int sizes [8] = '{1, 4, 8, 2, 4, 8, 3, 1};
        void'($urandom(32'd2024));
        rst = 1'b1; req_valid = 0; req_write = 0; req_offset = 0; req_size = 0;
        req_wdata = 0; spi_count = 0; reg_rdata = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(dec_valid == 0 && dec_wr_en == 0 && rsp_rdata == 0, "R10", "reset",
              {62'd0, dec_valid, dec_wr_en}, 64'd0);
        rst = 1'b0;

        // R1: region edges
        access('h0080, 4, 0, 0, 0, 64'hDEAD_BEEF_1234_5678, "R1");
        access('h00FC, 4, 0, 0, 0, 64'h1111_2222_3333_4444, "R1");
        access('h0010, 4, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
        access('h3000, 4, 1, 0, 64'hAAAA_BBBB_CCCC_DDDD, 0, "R1");
        // R2: illegal sizes
        access('h0400, 2, 0, 100, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        access('h0400, 3, 1, 100, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R2");
        // R3: size permission
        access('h0004, 1, 0, 0, 0, 64'h0123_4567_89AB_CDEF, "R3");
        access('h6008, 8, 0, 900, 0, 64'h0123_4567_89AB_CDEF, "R3");
        access('h0408, 8, 1, 900, 64'h1, 0, "R3");
        // R4: alignment
        access('h0406, 4, 0, 900, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        access('h6004, 8, 1, 900, 64'h5555_5555_5555_5555, 0, "R4");
        // R5: interrupt limit, spi=8 -> 40 interrupts; priority byte 39 ok, 40 not
        access('h0427, 1, 1, 8, 64'hFF, 0, "R5");
        access('h0428, 1, 1, 8, 64'hFF, 0, "R5");
        access('h0084, 4, 0, 0, 0, 64'h7777_8888, "R5");
        access('h0084, 4, 0, 1, 0, 64'h7777_8888, "R5");
        // R6: no interrupt limit in region 0
        access('h000C, 4, 1, 0, 64'h9999_AAAA_BBBB_CCCC, 0, "R6");
        // R8: byte lanes on 1-byte access
        access('h0401, 1, 0, 500, 0, 64'hFEDC_BA98_7654_3210, "R8");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int r = $urandom_range(0, 5);
            int off;
            if ($urandom_range(0, 4) == 0) off = $urandom_range(0, 'hFFFF);
            else off = T_BASE[r] + $urandom_range(0, T_LEN[r] + 7) - 4;
            if (off < 0) off = 0;
            access(off, sizes[$urandom_range(0, 7)], 1'($urandom_range(0, 1)),
                   $urandom_range(0, 1023),
                   {$urandom, $urandom}, {$urandom, $urandom}, "R1-rand");
        end

        // R10: idle after valid drops
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(dec_valid == 0 && dec_wr_en == 0, "R10", "idle",
              {62'd0, dec_valid, dec_wr_en}, 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule